// File: doc/BRIEF.md
# I2C Byte-Addressed Target with Paged Writes

This block is the serial front end of a small register and memory bank. It is clocked by a system clock that is much faster than the bus. It oversamples SCL and SDA and finds start, repeated start and stop conditions on the bus. It answers a 7-bit device address made of a fixed four-bit prefix and three strap inputs.

After a write address, the first byte is a memory pointer. Each byte after it is handed to the back end as a one-cycle write strobe, with an address and a data value. After a read address, the block fetches bytes from the back end through a one-cycle read strobe, starting at the current pointer. It keeps sending bytes while the host acknowledges.

One pointer serves both directions. On writes it advances only inside an aligned 8-byte page. On reads it advances through the whole 8-bit space. While the back end reports a commit in progress, the block refuses its own address. A host can therefore poll the device until the commit has finished.

Top module: `i2c_page_target`

## Requirements
- R1: The device address byte is `1010` in bits 7:4, `strap_i[2]`, `strap_i[1]`, `strap_i[0]` in bits 3:1, and R/W in bit 0, where 0 means write. On a match the block drives the ninth bit low. On a mismatch it leaves SDA released and ignores every following byte until the next start condition.
- R2: While `busy_i` is high at the end of the address byte, the address is not acknowledged. No write strobe and no read strobe follow in that transaction.
- R3: In a write, the byte after the address loads the pointer. The next data byte is presented on `wdata_o`, with `addr_o` equal to that pointer, during a one-cycle `wr_stb_o`.
- R4: On writes, the pointer steps only in bits 2:0. A write that runs past the last byte of an 8-aligned page continues at the base of the same page.
- R5: A read sends data from the current pointer without taking a new address. After each byte the pointer steps by one over the full 8-bit range, so that FFh is followed by 00h.
- R6: During a read, a host ACK after a byte makes the block send the next byte. A host NACK makes it release SDA and fetch nothing more until the next start.
- R7: Bits travel MSB first, and the receiver acknowledges in the ninth bit with a low level. The block changes its SDA drive only while SCL is low.
- R8: `stop_o` pulses for one cycle at a stop condition only if at least one data byte was written since the previous stop. A pointer-only write does not make it pulse.
- R9: While `rst` is high and just after it, SDA is released and all strobes are low.
- R10: Every byte sent on a read comes from `rdata_i`, sampled during a one-cycle `rd_stb_o` with `addr_o` at the pointer. A write strobe and a read strobe never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| strap_i | input | 3 | Low three bits of the device address |
| busy_i | input | 1 | Back end is committing; address is refused |
| rdata_i | input | 8 | Back-end read data for `addr_o` |
| sda_drive_o | output | 1 | 1 pulls SDA low (open drain) |
| wr_stb_o | output | 1 | One-cycle write strobe |
| rd_stb_o | output | 1 | One-cycle read fetch strobe |
| addr_o | output | 8 | Current byte pointer |
| wdata_o | output | 8 | Write data during `wr_stb_o` |
| stop_o | output | 1 | Stop seen after data was written |

## Verification
The hardest state to reach is a read that crosses FFh to 00h right after the pointer has been placed at FFh. That state needs a pointer-only write to the top of the space, then a repeated start with a read address, then a host ACK in the middle of the read. The bench first fills the bytes at FFh and the bottom of the space through paged writes. It then runs that sequence and afterwards reads with no new pointer, which shows where the pointer was left. Page wrap is reached by starting a five-byte write three bytes before the end of a page and reading the whole page back.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int          ADDR_W     = 8;
    localparam logic [3:0]  DEV_PREFIX = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_MEM,
        ST_MEM_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_RD_NEXT,
        ST_SKIP
    } tgt_state_e;

    typedef struct packed {
        logic scl;
        logic scl_rise;
        logic scl_fall;
        logic sda;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic dev_hit(input logic [7:0] b, input logic [2:0] strap);
        return b[7:1] == {DEV_PREFIX, strap};
    endfunction

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [SYNC_STAGES-1:0] scl_ff;
    logic [SYNC_STAGES-1:0] sda_ff;
    logic                   scl_d;
    logic                   sda_d;
    logic                   scl_s;
    logic                   sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
            scl_d  <= scl_s;
            sda_d  <= sda_s;
        end
    end

    assign scl_s = scl_ff[SYNC_STAGES-1];
    assign sda_s = sda_ff[SYNC_STAGES-1];

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_d;
        ev.scl_fall = ~scl_s & scl_d;
        ev.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop     = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/i2c_addr_ctr.sv
module i2c_addr_ctr #(
    parameter int AW = 8,
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          wr_step,
    input  logic          rd_step,
    output logic [AW-1:0] ptr
);

    localparam logic [AW-1:0] PAGE_MASK = AW'((1 << PW) - 1);

    logic [AW-1:0] ptr_inc;
    logic [AW-1:0] ptr_page;

    assign ptr_inc  = ptr + 1'b1;
    assign ptr_page = (ptr_inc & PAGE_MASK) | (ptr & ~PAGE_MASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (wr_step) begin
            ptr <= ptr_page;
        end else if (rd_step) begin
            ptr <= ptr_inc;
        end
    end

    // R4: a write step never leaves the current page
    assert_page_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_step && !load) |=> ptr[AW-1:PW] == $past(ptr[AW-1:PW]));

    // R5: a read step moves to the next address over the full range
    assert_read_step_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_step && !wr_step && !load) |=> ptr == $past(ptr) + 1'b1);

endmodule

// File: rtl/i2c_page_target.sv
module i2c_page_target
    import i2c_tgt_pkg::*;
#(
    parameter int PAGE_BITS   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        strap_i,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] rdata_i,
    output logic              sda_drive_o,
    output logic              wr_stb_o,
    output logic              rd_stb_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] wdata_o,
    output logic              stop_o
);

    bus_ev_t    ev;
    tgt_state_e state;
    logic [2:0] bitcnt;
    logic [6:0] rx_sh;
    logic [6:0] tx_sh;
    logic [7:0] rx_byte;
    logic       sda_low;
    logic       ack_drv;
    logic       rw;
    logic       wrote;
    logic       wr_stb_q;
    logic       rd_stb_q;
    logic       stop_q;
    logic [7:0] wdata_q;
    logic       rx_last;
    logic       ptr_load;
    logic [ADDR_W-1:0] ptr;

    i2c_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    assign rx_byte  = {rx_sh, ev.sda};
    assign rx_last  = ev.scl_rise && (bitcnt == 3'd7);
    assign ptr_load = (state == ST_MEM) && rx_last;

    i2c_addr_ctr #(.AW(ADDR_W), .PW(PAGE_BITS)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (ptr_load),
        .load_val (rx_byte),
        .wr_step  (wr_stb_q),
        .rd_step  (rd_stb_q),
        .ptr      (ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            sda_low  <= 1'b0;
            ack_drv  <= 1'b0;
            rw       <= 1'b0;
            wrote    <= 1'b0;
            wr_stb_q <= 1'b0;
            rd_stb_q <= 1'b0;
            stop_q   <= 1'b0;
            wdata_q  <= '0;
        end else begin
            wr_stb_q <= 1'b0;
            rd_stb_q <= 1'b0;
            stop_q   <= 1'b0;
            if (rd_stb_q) begin
                tx_sh   <= rdata_i[6:0];
                sda_low <= ~rdata_i[7];
            end
            if (ev.start) begin
                state   <= ST_DEV;
                bitcnt  <= '0;
                sda_low <= 1'b0;
                ack_drv <= 1'b0;
            end else if (ev.stop) begin
                state   <= ST_IDLE;
                sda_low <= 1'b0;
                stop_q  <= wrote;
                wrote   <= 1'b0;
            end else begin
                unique case (state)
                    ST_DEV, ST_MEM, ST_WR: begin
                        if (ev.scl_rise) begin
                            rx_sh  <= rx_byte[6:0];
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) begin
                                ack_drv <= 1'b0;
                                if (state == ST_DEV) begin
                                    if (dev_hit(rx_byte, strap_i) && !busy_i) begin
                                        rw    <= rx_byte[0];
                                        state <= ST_DEV_ACK;
                                    end else begin
                                        state <= ST_SKIP;
                                    end
                                end else if (state == ST_MEM) begin
                                    state <= ST_MEM_ACK;
                                end else begin
                                    wdata_q  <= rx_byte;
                                    wr_stb_q <= 1'b1;
                                    wrote    <= 1'b1;
                                    state    <= ST_WR_ACK;
                                end
                            end
                        end
                    end
                    ST_DEV_ACK, ST_MEM_ACK, ST_WR_ACK: begin
                        if (ev.scl_fall) begin
                            if (!ack_drv) begin
                                sda_low <= 1'b1;
                                ack_drv <= 1'b1;
                            end else begin
                                sda_low <= 1'b0;
                                bitcnt  <= '0;
                                if (state == ST_DEV_ACK && rw) begin
                                    rd_stb_q <= 1'b1;
                                    state    <= ST_RD;
                                end else if (state == ST_DEV_ACK) begin
                                    state <= ST_MEM;
                                end else begin
                                    state <= ST_WR;
                                end
                            end
                        end
                    end
                    ST_RD: begin
                        if (ev.scl_rise) begin
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) begin
                                state <= ST_RD_ACK;
                            end
                        end else if (ev.scl_fall) begin
                            tx_sh   <= {tx_sh[5:0], 1'b0};
                            sda_low <= ~tx_sh[6];
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.scl_fall) begin
                            sda_low <= 1'b0;
                        end else if (ev.scl_rise) begin
                            state <= ev.sda ? ST_SKIP : ST_RD_NEXT;
                        end
                    end
                    ST_RD_NEXT: begin
                        if (ev.scl_fall) begin
                            rd_stb_q <= 1'b1;
                            bitcnt   <= '0;
                            state    <= ST_RD;
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    assign sda_drive_o = sda_low;
    assign wr_stb_o    = wr_stb_q;
    assign rd_stb_o    = rd_stb_q;
    assign addr_o      = ptr;
    assign wdata_o     = wdata_q;
    assign stop_o      = stop_q;

    // R7: the drive on SDA is only asserted while SCL is low
    assert_drive_scl_low_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_low) |-> !ev.scl);

    // R10: fetch and store strobes are never together
    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_stb_q, rd_stb_q}));

    // R2: an address that ends while busy is not acknowledged
    assert_busy_nack_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DEV && rx_last && busy_i && !ev.start && !ev.stop)
        |=> (state == ST_SKIP && !sda_low));

    // R1: an ignored transaction never pulls SDA low
    assert_skip_silent_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |-> !sda_low);

    // R6: no fetch is made after the host declines a byte
    assert_nack_no_fetch_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |-> !rd_stb_q);

endmodule

// File: tb/test_i2c_page_target.sv
module test_i2c_page_target;

    localparam int CLK_PERIOD  = 10;
    localparam int QTR         = 8;
    localparam int WDOG_CYCLES = 150000;

    logic       clk   = 1'b0;
    logic       rst   = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b000;
    logic       busy  = 1'b0;

    logic       sda_drive;
    logic       wr_stb;
    logic       rd_stb;
    logic       stop_pls;
    logic [7:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       sda_bus;

    logic [7:0] bmem    [256];
    logic [7:0] exp_mem [256];
    logic [7:0] wbuf    [8];
    logic [7:0] rbuf    [8];

    int   n_wr = 0, n_rd = 0, n_stop = 0, viol = 0;
    int   errors = 0, checks = 0;
    logic [7:0] last_waddr = '0, last_wdata = '0;
    logic prev_drive = 1'b0;
    logic ack_dev;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus = sda_m & ~sda_drive;
    assign rdata   = bmem[addr];

    i2c_page_target i_i2c_page_target (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .strap_i     (strap),
        .busy_i      (busy),
        .rdata_i     (rdata),
        .sda_drive_o (sda_drive),
        .wr_stb_o    (wr_stb),
        .rd_stb_o    (rd_stb),
        .addr_o      (addr),
        .wdata_o     (wdata),
        .stop_o      (stop_pls)
    );

    // back end memory and event monitors
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) bmem[i] <= 8'h00;
        end else begin
            if (wr_stb) begin
                bmem[addr] <= wdata;
                n_wr       <= n_wr + 1;
                last_waddr <= addr;
                last_wdata <= wdata;
            end
            if (rd_stb)   n_rd   <= n_rd + 1;
            if (stop_pls) n_stop <= n_stop + 1;
            if (sda_drive && !prev_drive && scl_m) viol <= viol + 1;
        end
        prev_drive <= sda_drive;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic qwait();
        repeat (QTR) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    qwait();
        scl_m = 1'b1; qwait(); qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        b = sda_bus;  qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        get_bit(ack);
    endtask

    task automatic read_byte(output logic [7:0] b, input logic last);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            get_bit(v);
            b[i] = v;
        end
        send_bit(last);
    endtask

    // write n bytes from wbuf starting at ma; returns the address ack level
    task automatic write_seq(input logic [7:0] dev, input logic [7:0] ma, input int n);
        logic a;
        bus_start();
        write_byte(dev, ack_dev);
        write_byte(ma, a);
        for (int i = 0; i < n; i++) write_byte(wbuf[i], a);
        bus_stop();
    endtask

    // place the pointer with a pointer-only write, then read n bytes into rbuf
    task automatic ptr_read(input logic [7:0] dev, input logic [7:0] ma, input int n);
        logic a;
        bus_start();
        write_byte(dev, a);
        write_byte(ma, a);
        bus_start();
        write_byte(dev | 8'h01, ack_dev);
        for (int i = 0; i < n; i++) read_byte(rbuf[i], (i == n - 1));
        bus_stop();
    endtask

    // expected write of the model: pointer steps inside its 8-byte page
    task automatic model_write(input logic [7:0] ma, input int n);
        logic [7:0] p = ma;
        for (int i = 0; i < n; i++) begin
            exp_mem[p] = wbuf[i];
            p = {p[7:3], p[2:0] + 3'd1};
        end
    endtask

    task automatic t_reset();
        chk("R9 drive in reset", sda_drive, 0);
        chk("R9 strobes in reset", {wr_stb, rd_stb, stop_pls}, 0);
        @(posedge clk); #1;
        rst = 1'b0;
        repeat (3) @(posedge clk); #1;
        chk("R9 drive after reset", sda_drive, 0);
        chk("R9 strobes after reset", {wr_stb, rd_stb, stop_pls}, 0);
    endtask

    task automatic t_single_write();
        int w0 = n_wr, s0 = n_stop, r0 = n_rd;
        wbuf[0] = 8'h5A;
        write_seq(8'hA0, 8'h10, 1);
        model_write(8'h10, 1);
        chk("R1 address ack", ack_dev, 0);
        chk("R3 one write strobe", n_wr - w0, 1);
        chk("R3 write address", last_waddr, 8'h10);
        chk("R3 write data", last_wdata, 8'h5A);
        chk("R8 stop after data", n_stop - s0, 1);
        s0 = n_stop;
        ptr_read(8'hA0, 8'h10, 1);
        chk("R7 read MSB first", rbuf[0], exp_mem[8'h10]);
        chk("R10 one fetch", n_rd - r0, 1);
        chk("R8 no stop after pointer-only write", n_stop - s0, 0);
    endtask

    task automatic t_page_wrap();
        for (int i = 0; i < 5; i++) wbuf[i] = 8'hA1 + 8'(i);
        write_seq(8'hA0, 8'h1D, 5);
        model_write(8'h1D, 5);
        chk("R4 last address wrapped", last_waddr, 8'h19);
        ptr_read(8'hA0, 8'h18, 8);
        for (int i = 0; i < 8; i++) chk("R4 page content", rbuf[i], exp_mem[8'h18 + i]);
    endtask

    task automatic t_read_wrap();
        logic [7:0] b;
        wbuf[0] = 8'hC3;
        write_seq(8'hA0, 8'hFF, 1);
        model_write(8'hFF, 1);
        wbuf[0] = 8'h3C; wbuf[1] = 8'h5D; wbuf[2] = 8'h77;
        write_seq(8'hA0, 8'h00, 3);
        model_write(8'h00, 3);
        ptr_read(8'hA0, 8'hFF, 3);
        chk("R5 byte at FFh", rbuf[0], exp_mem[8'hFF]);
        chk("R5 wrap to 00h", rbuf[1], exp_mem[8'h00]);
        chk("R5 then 01h", rbuf[2], exp_mem[8'h01]);
        bus_start();
        write_byte(8'hA1, ack_dev);
        read_byte(b, 1'b1);
        bus_stop();
        chk("R5 read without pointer", b, exp_mem[8'h02]);
    endtask

    task automatic t_nack_release();
        logic a;
        logic [7:0] b;
        logic [7:0] extra;
        int r0 = n_rd;
        bus_start();
        write_byte(8'hA0, a);
        write_byte(8'h18, a);
        bus_start();
        write_byte(8'hA1, a);
        read_byte(b, 1'b0);
        read_byte(b, 1'b1);
        chk("R6 released after NACK", sda_drive, 0);
        for (int i = 7; i >= 0; i--) begin
            get_bit(a);
            extra[i] = a;
        end
        chk("R6 bus idle after NACK", extra, 8'hFF);
        bus_stop();
        chk("R6 fetch count", n_rd - r0, 2);
    endtask

    task automatic t_mismatch();
        logic a;
        int w0 = n_wr, s0 = n_stop;
        strap = 3'b101;
        bus_start();
        write_byte(8'hA0, a);
        chk("R1 mismatch not acked", a, 1);
        write_byte(8'h20, a);
        chk("R1 ignored byte not acked", a, 1);
        write_byte(8'h99, a);
        bus_stop();
        chk("R1 no write after mismatch", n_wr - w0, 0);
        chk("R8 no stop after mismatch", n_stop - s0, 0);
        wbuf[0] = 8'h66;
        write_seq(8'hAA, 8'h20, 1);
        model_write(8'h20, 1);
        chk("R1 strap address acked", ack_dev, 0);
        ptr_read(8'hAA, 8'h20, 1);
        chk("R1 strap address data", rbuf[0], exp_mem[8'h20]);
        strap = 3'b000;
    endtask

    task automatic t_busy();
        logic b;
        logic [7:0] d;
        int w0 = n_wr, r0 = n_rd;
        busy = 1'b1;
        wbuf[0] = 8'h44;
        write_seq(8'hA0, 8'h30, 1);
        chk("R2 write address refused", ack_dev, 1);
        chk("R2 no write while busy", n_wr - w0, 0);
        bus_start();
        write_byte(8'hA1, b);
        chk("R2 read address refused", b, 1);
        read_byte(d, 1'b1);
        bus_stop();
        chk("R2 no fetch while busy", n_rd - r0, 0);
        busy = 1'b0;
        write_seq(8'hA0, 8'h30, 1);
        model_write(8'h30, 1);
        chk("R2 acked when idle", ack_dev, 0);
        chk("R2 write when idle", n_wr - w0, 1);
    endtask

    initial begin : wdog
        repeat (WDOG_CYCLES) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
        repeat (4) @(posedge clk);
        #1;
        t_reset();
        t_single_write();
        t_page_wrap();
        t_read_wrap();
        t_nack_release();
        t_mismatch();
        t_busy();
        chk("R7 drive only while SCL low", viol, 0);
        summary();
        $finish;
    end

endmodule